// File: doc/BRIEF.md
# Xorshift-Rotate 64-bit Random Generator

This block is a non-cryptographic pseudo-random word source for noise generation, Monte-Carlo stimulus and similar uses. It holds 128 bits of state as two 64-bit halves, a low half `lo` and a high half `hi`. On every clock cycle where the enable is high, it registers one complete 64-bit output word. In the same cycle it advances the state by a mix of XOR, fixed rotations and one fixed shift.

The output word is the sum of the two halves modulo 2^64, taken from the state before that cycle's update. The adder and the state mixing each sit in front of their own register, so neither path passes through the other. A 128-bit seed can be loaded at any time with a one-cycle strobe. An all-zero seed would lock the recurrence at zero, so the block swaps it for a fixed nonzero fill value. The same fill value is also the state after reset.

Top module: `prng128_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `rnd_valid` becomes 0, `rnd_word` becomes 0 and the state becomes the fill value: `lo` = 64'hD1B54A32D192ED03, `hi` = 64'h9E3779B97F4A7C15.
- R2: On an edge where `en` is 1 and `reseed` is 0, `rnd_word` takes (lo + hi) mod 2^64 of the state before that edge, with the carry out of bit 63 discarded.
- R3: On the same edge, with x = lo XOR hi, the new `lo` is rotl(lo,55) XOR x XOR (x << 14) and the new `hi` is rotl(x,36). Rotations and the shift are on 64 bits.
- R4: On an edge where `en` and `reseed` are both 0, the state, `rnd_word` and `rnd_valid` all keep their values.
- R5: On an edge where `reseed` is 1, the state loads from `seed`: `seed[63:0]` goes to `lo` and `seed[127:64]` goes to `hi`.
- R6: A reseed with an all-zero `seed` loads the R1 fill value instead of zero.
- R7: `rnd_valid` is 0 after an edge with `reseed` high. It is 1 after each edge with `en` high and `reseed` low.
- R8: When `reseed` and `en` are both 1, the reseed wins. The state is loaded, no word is produced, `rnd_word` holds its value and `rnd_valid` goes to 0.
- R9: Outside reset, the 128-bit state is never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Produce one word and advance the state on this edge |
| reseed | input | 1 | Load the state from `seed` on this edge |
| seed | input | 128 | New state: low half in [63:0], high half in [127:64] |
| rnd_word | output | 64 | Registered random word |
| rnd_valid | output | 1 | `rnd_word` holds a word produced since the last load |

## Verification
The bound checker looks at every cycle. It confirms that a hold cycle freezes the word, the flag and the state, and that a reseed clears the flag whatever the enable does. It also confirms that an all-zero seed is replaced by the fill value and that the state never reaches zero. It relates each new word to the sum of the previous state's halves.

Only the bench scenarios can show that the mixing recurrence is right. They compare a long run from a known seed against an independently written model. They also cover the wrapping carry in the adder, resuming correctly after pauses, and which seed half lands in which state half.

// File: rtl/prng128_pkg.sv
package prng128_pkg;
  parameter int unsigned WORD_W = 64;
  parameter int unsigned STATE_W = 2 * WORD_W;
  parameter int unsigned MIX_ROT_LO = 55;
  parameter int unsigned MIX_SHL = 14;
  parameter int unsigned MIX_ROT_HI = 36;
  parameter logic [STATE_W-1:0] FILL_STATE =
    {64'h9E3779B97F4A7C15, 64'hD1B54A32D192ED03};

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t mix_lo(input word_t lo, input word_t hi);
    word_t x;
    x = lo ^ hi;
    return rotl(lo, MIX_ROT_LO) ^ x ^ (x << MIX_SHL);
  endfunction

  function automatic word_t mix_hi(input word_t lo, input word_t hi);
    return rotl(lo ^ hi, MIX_ROT_HI);
  endfunction

  function automatic word_t sum_halves(input word_t lo, input word_t hi);
    return lo + hi;
  endfunction

  function automatic logic [STATE_W-1:0] seed_fix(input logic [STATE_W-1:0] s);
    return (s == '0) ? FILL_STATE : s;
  endfunction
endpackage

// File: rtl/prng128_state.sv
module prng128_state
  import prng128_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               reseed,
  input  logic [STATE_W-1:0] seed,
  output word_t              st_lo,
  output word_t              st_hi,
  output logic               adv_evt,
  output logic               load_evt
);
  logic [STATE_W-1:0] seed_ok;

  assign load_evt = reseed;
  assign adv_evt  = en & ~reseed;
  assign seed_ok  = seed_fix(seed);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_lo <= FILL_STATE[WORD_W-1:0];
      st_hi <= FILL_STATE[STATE_W-1:WORD_W];
    end else if (load_evt) begin
      st_lo <= seed_ok[WORD_W-1:0];
      st_hi <= seed_ok[STATE_W-1:WORD_W];
    end else if (adv_evt) begin
      st_lo <= mix_lo(st_lo, st_hi);
      st_hi <= mix_hi(st_lo, st_hi);
    end
  end
endmodule

// File: rtl/prng128_out.sv
module prng128_out
  import prng128_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv_evt,
  input  logic  load_evt,
  input  word_t st_lo,
  input  word_t st_hi,
  output word_t rnd_word,
  output logic  rnd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_word  <= '0;
      rnd_valid <= 1'b0;
    end else if (load_evt) begin
      rnd_valid <= 1'b0;
    end else if (adv_evt) begin
      rnd_word  <= sum_halves(st_lo, st_hi);
      rnd_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/prng128_gen.sv
module prng128_gen
  import prng128_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               reseed,
  input  logic [STATE_W-1:0] seed,
  output logic [WORD_W-1:0]  rnd_word,
  output logic               rnd_valid
);
  word_t st_lo;
  word_t st_hi;
  logic  adv_evt;
  logic  load_evt;

  prng128_state u_state (
    .clk(clk), .rst(rst), .en(en), .reseed(reseed), .seed(seed),
    .st_lo(st_lo), .st_hi(st_hi), .adv_evt(adv_evt), .load_evt(load_evt)
  );

  prng128_out u_out (
    .clk(clk), .rst(rst), .adv_evt(adv_evt), .load_evt(load_evt),
    .st_lo(st_lo), .st_hi(st_hi), .rnd_word(rnd_word), .rnd_valid(rnd_valid)
  );
endmodule

// File: rtl/prng128_chk.sv
module prng128_chk
  import prng128_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic               reseed,
  input logic [STATE_W-1:0] seed,
  input logic [WORD_W-1:0]  rnd_word,
  input logic               rnd_valid,
  input logic [WORD_W-1:0]  st_lo,
  input logic [WORD_W-1:0]  st_hi
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rnd_valid && rnd_word == '0));

  // R2
  word_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !reseed) |=> rnd_word == WORD_W'($past(st_lo) + $past(st_hi)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !reseed) |=> ($stable(rnd_word) && $stable(rnd_valid)
                          && $stable(st_lo) && $stable(st_hi)));

  // R6
  zero_seed_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (reseed && seed == '0) |=> {st_hi, st_lo} == FILL_STATE);

  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    reseed |=> !rnd_valid);

  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !reseed) |=> rnd_valid);

  // R8
  reseed_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (reseed && en) |=> $stable(rnd_word));

  // R9
  nonzero_state_chk: assert property (@(posedge clk) disable iff (rst)
    (st_lo | st_hi) != '0);
endmodule

bind prng128_gen prng128_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .reseed(reseed), .seed(seed),
  .rnd_word(rnd_word), .rnd_valid(rnd_valid), .st_lo(st_lo), .st_hi(st_hi)
);

// File: tb/prng128_gen_tb.sv
`timescale 1ns/1ps
module prng128_gen_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         reseed = 1'b0;
  logic [127:0] seed = '0;
  logic [63:0]  rnd_word;
  logic         rnd_valid;

  int checks = 0;
  int failures = 0;
  logic [63:0] m_lo, m_hi;

  localparam logic [63:0] FILL_LO = 64'hD1B54A32D192ED03;
  localparam logic [63:0] FILL_HI = 64'h9E3779B97F4A7C15;

  always #5 clk = ~clk;

  prng128_gen u_dut (
    .clk(clk), .rst(rst), .en(en), .reseed(reseed), .seed(seed),
    .rnd_word(rnd_word), .rnd_valid(rnd_valid)
  );

  task automatic chk(input logic ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // model: advance once, return word produced
  task automatic model_step(output logic [63:0] w);
    logic [63:0] x, a, b;
    w = m_lo + m_hi;
    x = m_lo ^ m_hi;
    a = {m_lo[8:0], m_lo[63:9]} ^ x ^ {x[49:0], 14'b0};
    b = {x[27:0], x[63:28]};
    m_lo = a;
    m_hi = b;
  endtask

  task automatic load(input logic [127:0] s, input logic with_en);
    seed = s; reseed = 1'b1; en = with_en;
    tick();
    reseed = 1'b0; en = 1'b0;
    if (s == '0) begin m_lo = FILL_LO; m_hi = FILL_HI; end
    else begin m_lo = s[63:0]; m_hi = s[127:64]; end
  endtask

  task automatic run(input int n, input string req);
    logic [63:0] w;
    en = 1'b1;
    for (int i = 0; i < n; i++) begin
      tick();
      model_step(w);
      chk(rnd_word == w, req, rnd_word, w);
      chk(rnd_valid == 1'b1, "R7", {63'b0, rnd_valid}, 64'd1);
    end
    en = 1'b0;
  endtask

  task automatic t_reset();
    tick(); tick();
    chk(rnd_valid == 1'b0, "R1", {63'b0, rnd_valid}, 64'd0);
    chk(rnd_word == 64'd0, "R1", rnd_word, 64'd0);
    rst = 1'b0;
    m_lo = FILL_LO; m_hi = FILL_HI;
    run(4, "R1");
  endtask

  task automatic t_long_run();
    load({64'h0123456789ABCDEF, 64'hFEDCBA9876543210}, 1'b0);
    chk(rnd_valid == 1'b0, "R7", {63'b0, rnd_valid}, 64'd0);
    run(1000, "R3");
  endtask

  task automatic t_seed_halves();
    load({64'h0, 64'h1}, 1'b0);
    run(1, "R5");
    load({64'h5, 64'h0}, 1'b0);
    run(3, "R5");
  endtask

  task automatic t_carry();
    load({64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF}, 1'b0);
    run(1, "R2");
    load({64'h8000000000000000, 64'h8000000000000001}, 1'b0);
    run(2, "R2");
  endtask

  task automatic t_hold();
    logic [63:0] held;
    load({64'hA5A5A5A5A5A5A5A5, 64'h3C3C3C3C3C3C3C3C}, 1'b0);
    run(5, "R2");
    held = rnd_word;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk(rnd_word == held, "R4", rnd_word, held);
      chk(rnd_valid == 1'b1, "R4", {63'b0, rnd_valid}, 64'd1);
    end
    run(5, "R4");
    en = 1'b1; tick(); en = 1'b0; tick(); en = 1'b1; tick(); en = 1'b0;
    begin
      logic [63:0] w;
      model_step(w); model_step(w);
      chk(rnd_word == w, "R4", rnd_word, w);
    end
  endtask

  task automatic t_zero_seed();
    load('0, 1'b0);
    chk(rnd_valid == 1'b0, "R7", {63'b0, rnd_valid}, 64'd0);
    run(20, "R6");
  endtask

  task automatic t_reseed_priority();
    logic [63:0] held;
    load({64'h1111, 64'h2222}, 1'b0);
    run(3, "R8");
    held = rnd_word;
    load({64'h0000DEAD0000BEEF, 64'h00000000CAFEF00D}, 1'b1);
    chk(rnd_word == held, "R8", rnd_word, held);
    chk(rnd_valid == 1'b0, "R8", {63'b0, rnd_valid}, 64'd0);
    run(3, "R8");
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_long_run();
    t_seed_halves();
    t_carry();
    t_hold();
    t_zero_seed();
    t_reseed_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule